// File: doc/BRIEF.md
# Multi-Step 32-bit Processor Core

This block is a small 32-bit processor that runs each instruction as a sequence of short clock steps. One ALU and one memory port are shared across those steps. A state machine sets the write enables and the mux selects in every step. The memory port carries an address, write data, a write enable and read data. It serves both instruction fetch and data access. The memory sits outside the block and must return read data combinationally for the address presented in the same cycle. Writes land on the rising edge while the write enable is high.

Each instruction takes a number of cycles that depends on its class. A load takes five, a store or a register/immediate arithmetic operation takes four, and a branch or a jump takes three. An unsupported encoding is dropped after decode, so it takes two.

Inside the block the values move through several holding registers: an instruction register, a memory data register, two operand latches, an ALU result register, the program counter and a 32-entry register file. A one-cycle completion pulse lets the surrounding system count instructions and measure their latency.

Top module: `seqproc_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the block is in its fetch step: `mem_addr` is 0, `mem_we` is 0 and `done` is 0.
- R2: Every instruction is fetched from the program counter, and the fetch step advances the counter by 4. Without a taken branch or a jump, instructions run at consecutive word addresses starting at 0.
- R3: Opcode bits [31:26] = 0x00 selects a register operation on rs = [25:21] and rt = [20:16]. Funct [5:0] = 0x21 writes rs+rt to rd = [15:11], and funct 0x23 writes rs−rt to rd, both modulo 2^32. Each takes 4 cycles.
- R4: Opcode 0x0D writes rs OR the zero-extended [15:0] to rt, in 4 cycles.
- R5: Opcode 0x23 reads memory at rs plus the sign-extended [15:0] and writes the word to rt, in 5 cycles.
- R6: Opcode 0x2B writes rt to memory at rs plus the sign-extended [15:0], in 4 cycles. `mem_we` is high for exactly one cycle per store and at no other time.
- R7: Opcode 0x04 compares rs and rt, in 3 cycles. If they are equal, the next instruction comes from (address+4) + (sign-extended [15:0] shifted left by 2). Otherwise it comes from address+4.
- R8: Opcode 0x02 jumps, in 3 cycles, to {bits [31:28] of address+4, [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, or opcode 0x00 with any other funct, completes in 2 cycles and writes neither a register nor memory.
- R11: `done` goes high for exactly one cycle, in the cycle that follows the last step of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, written at the rising edge |
| mem_rdata | input | 32 | Read data for `mem_addr`, combinational |
| done | output | 1 | One-cycle instruction completion pulse |

## Verification
The first instruction is fetched at the first rising edge after reset is released. The completion pulse of an instruction that takes N cycles is therefore seen after the Nth edge of that instruction. The bench counts edges from reset release and adds up the expected per-class cycle counts. It compares each pulse's edge number with that running total, sampling on the falling edge so the registered pulse has settled. In the same pulse cycle the core is already fetching the next instruction, so `mem_addr` at that moment is checked against the expected control-flow successor. Register and store results are not visible until a store commits them at the end of its fourth cycle, so memory contents are compared only after the program has settled into its terminal self-branch.

// File: rtl/seqproc_pkg.sv
`timescale 1ns/1ps
package seqproc_pkg;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_ORIMM = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MREAD, S_LDWB,
    S_MWRITE, S_EXEC, S_ALUWB, S_BRANCH, S_JUMP
  } state_t;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} aluop_t;
  typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM, SB_IMM_SH} srcb_t;
  typedef enum logic [1:0] {PCS_ALU, PCS_ALUOUT, PCS_JUMP} pcsrc_t;

  typedef struct packed {
    logic   pc_we;
    pcsrc_t pc_src;
    logic   ir_we;
    logic   addr_alu;
    logic   mem_we;
    logic   src_a_reg;
    srcb_t  src_b;
    logic   zext;
    aluop_t alu_op;
    logic   rf_we;
    logic   rf_from_mdr;
    logic   dst_rd;
    logic   last;
  } ctrl_t;

endpackage

// File: rtl/seqproc_alu.sv
`timescale 1ns/1ps
module seqproc_alu
  import seqproc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_t       op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/seqproc_regfile.sv
`timescale 1ns/1ps
module seqproc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  // registered read ports double as the operand latches
  always_ff @(posedge clk) begin
    rd_a <= (ra_a == '0) ? '0 : mem[ra_a];
    rd_b <= (ra_b == '0) ? '0 : mem[ra_b];
  end

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |=> (rd_a == '0)); // R9
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
    (ra_b == '0) |=> (rd_b == '0)); // R9
endmodule

// File: rtl/seqproc_ctrl.sv
`timescale 1ns/1ps
module seqproc_ctrl
  import seqproc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       alu_zero,
  output ctrl_t      c,
  output state_t     state,
  output logic       done
);
  state_t nxt;
  logic   legal;
  logic   is_reg;

  assign is_reg = (opcode == OP_REG);
  always_comb begin
    unique case (opcode)
      OP_REG:                                  legal = (funct == FN_ADD) || (funct == FN_SUB);
      OP_ORIMM, OP_LOAD, OP_STORE, OP_BEQ, OP_JMP: legal = 1'b1;
      default:                                 legal = 1'b0;
    endcase
  end

  always_comb begin
    c   = '0;
    nxt = state;
    unique case (state)
      S_FETCH: begin
        c.ir_we = 1'b1; c.pc_we = 1'b1; c.pc_src = PCS_ALU;
        c.src_b = SB_FOUR; c.alu_op = ALU_ADD;
        nxt = S_DECODE;
      end
      S_DECODE: begin
        c.src_b = SB_IMM_SH; c.alu_op = ALU_ADD;
        if (!legal) begin
          c.last = 1'b1; nxt = S_FETCH;
        end else begin
          unique case (opcode)
            OP_LOAD, OP_STORE: nxt = S_MADDR;
            OP_BEQ:            nxt = S_BRANCH;
            OP_JMP:            nxt = S_JUMP;
            default:           nxt = S_EXEC;
          endcase
        end
      end
      S_MADDR: begin
        c.src_a_reg = 1'b1; c.src_b = SB_IMM; c.alu_op = ALU_ADD;
        nxt = (opcode == OP_LOAD) ? S_MREAD : S_MWRITE;
      end
      S_MREAD: begin
        c.addr_alu = 1'b1; nxt = S_LDWB;
      end
      S_LDWB: begin
        c.rf_we = 1'b1; c.rf_from_mdr = 1'b1; c.last = 1'b1; nxt = S_FETCH;
      end
      S_MWRITE: begin
        c.addr_alu = 1'b1; c.mem_we = 1'b1; c.last = 1'b1; nxt = S_FETCH;
      end
      S_EXEC: begin
        c.src_a_reg = 1'b1;
        if (is_reg) begin
          c.src_b  = SB_REG;
          c.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end else begin
          c.src_b = SB_IMM; c.zext = 1'b1; c.alu_op = ALU_OR;
        end
        nxt = S_ALUWB;
      end
      S_ALUWB: begin
        c.rf_we = 1'b1; c.dst_rd = is_reg; c.last = 1'b1; nxt = S_FETCH;
      end
      S_BRANCH: begin
        c.src_a_reg = 1'b1; c.src_b = SB_REG; c.alu_op = ALU_SUB;
        c.pc_src = PCS_ALUOUT; c.pc_we = alu_zero; c.last = 1'b1;
        nxt = S_FETCH;
      end
      S_JUMP: begin
        c.pc_src = PCS_JUMP; c.pc_we = 1'b1; c.last = 1'b1; nxt = S_FETCH;
      end
      default: nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= c.last;
    end
  end

  AST_RESET_TO_FETCH: assert property (@(posedge clk)
    rst |=> (state == S_FETCH && !done)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == S_FETCH)); // R11
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == S_LDWB) |-> ($past(state, 2) == S_MADDR)); // R5
endmodule

// File: rtl/seqproc_top.sv
`timescale 1ns/1ps
module seqproc_top
  import seqproc_pkg::*;
#(
  parameter int XW    = 32,
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [XW-1:0] mem_rdata,
  output logic          done
);
  localparam int RAW = $clog2(NREGS);

  ctrl_t        c;
  state_t       state;
  logic [XW-1:0] pc, ir, mdr, alu_out, a_q, b_q;
  logic [XW-1:0] alu_a, alu_b, alu_y, imm_ext, imm_sext, jump_tgt, rf_wd;
  logic          alu_zero;
  logic [RAW-1:0] rf_wa;

  seqproc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .funct(ir[5:0]),
    .alu_zero(alu_zero), .c(c), .state(state), .done(done)
  );

  assign imm_sext = {{(XW-16){ir[15]}}, ir[15:0]};
  assign imm_ext  = c.zext ? {{(XW-16){1'b0}}, ir[15:0]} : imm_sext;
  assign jump_tgt = {pc[XW-1:XW-4], ir[25:0], 2'b00};

  assign alu_a = c.src_a_reg ? a_q : pc;
  always_comb begin
    unique case (c.src_b)
      SB_REG:  alu_b = b_q;
      SB_FOUR: alu_b = XW'(4);
      SB_IMM:  alu_b = imm_ext;
      default: alu_b = {imm_sext[XW-3:0], 2'b00};
    endcase
  end

  seqproc_alu #(.W(XW)) u_alu (
    .a(alu_a), .b(alu_b), .op(c.alu_op), .y(alu_y), .zero(alu_zero)
  );

  assign rf_wa = c.dst_rd ? ir[15:11] : ir[20:16];
  assign rf_wd = c.rf_from_mdr ? mdr : alu_out;

  seqproc_regfile #(.W(XW), .DEPTH(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(c.rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra_a(ir[25:21]), .ra_b(ir[20:16]), .rd_a(a_q), .rd_b(b_q)
  );

  // holding registers without enables
  always_ff @(posedge clk) begin
    mdr     <= mem_rdata;
    alu_out <= alu_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (c.ir_we) ir <= mem_rdata;
      if (c.pc_we) begin
        unique case (c.pc_src)
          PCS_ALUOUT: pc <= alu_out;
          PCS_JUMP:   pc <= jump_tgt;
          default:    pc <= alu_y;
        endcase
      end
    end
  end

  assign mem_addr  = c.addr_alu ? alu_out : pc;
  assign mem_wdata = b_q;
  assign mem_we    = c.mem_we;

  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R2
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE) |-> (pc == $past(pc) + XW'(4))); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != S_FETCH) |=> $stable(ir)); // R2
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && state == S_FETCH)); // R6
endmodule

// File: tb/sim_seqproc_top.sv
`timescale 1ns/1ps
module sim_seqproc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, done;
  logic [31:0] ram [0:255];
  int          cyc = 0;
  int          wr_count = 0;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 0;

  int    exp_pc  [0:31];
  int    exp_len [0:31];
  string exp_tag [0:31];
  int    n = 0;

  always #2 clk = ~clk;

  seqproc_top u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done)
  );

  assign mem_rdata = ram[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr[9:2]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    cyc <= rst ? 0 : cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic put(input int addr, input logic [31:0] w, input int len, input string tag);
    ram[addr >> 2] = w;
    exp_pc[n] = addr; exp_len[n] = len; exp_tag[n] = tag; n++;
  endtask

  initial begin
    int acc;
    int nxt;
    for (int i = 0; i < 256; i++) ram[i] = 32'h0;
    ram[32'h200 >> 2] = 32'hDEADBEEF;
    ram[32'h204 >> 2] = 32'h13572468;
    ram[32'h110 >> 2] = 32'hA5A5A5A5;
    ram[32'h114 >> 2] = 32'hA5A5A5A5;

    put(0,  iop(6'h0D, 0, 1, 16'h8005), 4, "R4");
    put(4,  iop(6'h0D, 0, 2, 16'h0003), 4, "R4");
    put(8,  rop(1, 2, 3, 6'h21), 4, "R3");
    put(12, rop(2, 1, 4, 6'h23), 4, "R3");
    put(16, iop(6'h2B, 0, 3, 16'h0100), 4, "R6");
    put(20, iop(6'h2B, 0, 4, 16'h0104), 4, "R6");
    put(24, iop(6'h23, 0, 5, 16'h0200), 5, "R5");
    put(28, iop(6'h2B, 0, 5, 16'h0108), 4, "R6");
    put(32, iop(6'h0D, 0, 0, 16'h0055), 4, "R9");
    put(36, iop(6'h2B, 0, 0, 16'h010C), 4, "R9");
    put(40, iop(6'h04, 1, 2, 16'h0005), 3, "R7");
    put(44, iop(6'h04, 1, 1, 16'h0002), 3, "R7");
    ram[48 >> 2] = iop(6'h2B, 0, 1, 16'h0110);
    ram[52 >> 2] = iop(6'h2B, 0, 1, 16'h0110);
    put(56, iop(6'h3F, 1, 3, 16'h1234), 2, "R10");
    put(60, rop(1, 2, 4, 6'h00), 2, "R10");
    put(64, {6'h02, 26'd20}, 3, "R8");
    for (int a = 68; a < 80; a += 4) ram[a >> 2] = iop(6'h2B, 0, 1, 16'h0114);
    put(80, iop(6'h0D, 0, 7, 16'h0208), 4, "R4");
    put(84, iop(6'h23, 7, 6, 16'hFFFC), 5, "R5");
    put(88, iop(6'h2B, 0, 6, 16'h0118), 4, "R6");
    put(92, iop(6'h2B, 0, 4, 16'h011C), 4, "R10");
    put(96, iop(6'h04, 0, 0, 16'hFFFF), 3, "R7");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1", 32'(done), 32'h0);
    chk(mem_we == 1'b0, "R1", 32'(mem_we), 32'h0);
    chk(mem_addr == 32'h0, "R1", mem_addr, 32'h0);
    rst = 1'b0;

    acc = 0;
    for (int k = 0; k <= n; k++) begin
      int idx;
      idx = (k < n) ? k : n - 1;
      do @(negedge clk); while (!done);
      acc += exp_len[idx];
      chk(cyc == acc, exp_tag[idx], 32'(cyc), 32'(acc));
      nxt = (idx + 1 < n) ? exp_pc[idx + 1] : exp_pc[idx];
      chk(mem_addr == 32'(nxt), "R2", mem_addr, 32'(nxt));
      @(negedge clk);
      chk(done == 1'b0, "R11", 32'(done), 32'h0);
    end

    chk(ram[32'h100 >> 2] == 32'h00008008, "R3", ram[32'h100 >> 2], 32'h00008008);
    chk(ram[32'h104 >> 2] == 32'hFFFF7FFE, "R3", ram[32'h104 >> 2], 32'hFFFF7FFE);
    chk(ram[32'h108 >> 2] == 32'hDEADBEEF, "R5", ram[32'h108 >> 2], 32'hDEADBEEF);
    chk(ram[32'h10C >> 2] == 32'h0, "R9", ram[32'h10C >> 2], 32'h0);
    chk(ram[32'h110 >> 2] == 32'hA5A5A5A5, "R7", ram[32'h110 >> 2], 32'hA5A5A5A5);
    chk(ram[32'h114 >> 2] == 32'hA5A5A5A5, "R8", ram[32'h114 >> 2], 32'hA5A5A5A5);
    chk(ram[32'h118 >> 2] == 32'h13572468, "R5", ram[32'h118 >> 2], 32'h13572468);
    chk(ram[32'h11C >> 2] == 32'hFFFF7FFE, "R10", ram[32'h11C >> 2], 32'hFFFF7FFE);
    chk(wr_count == 6, "R6", 32'(wr_count), 32'd6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule